// File: doc/BRIEF.md
# Eight-Bit Prefix-Carry Arithmetic Logic Unit

This block is a small arithmetic logic unit that takes two 8-bit operands and an 8-line control word. It produces an 8-bit result and a carry-out flag, and it holds both in flip-flops. It performs one operation per clock, and the registered outputs show the operation that was presented before the most recent rising edge.

There is one arithmetic function, addition. Its carries come from a Brent-Kung parallel-prefix network that is fed by per-bit generate (A AND B) and propagate (A XOR B) terms, with the carry-in tied to zero. There are nine bitwise logic functions. Each function has its own fixed control code. Every candidate output is gated by a match on its code and then merged in a wide AND-OR stage. A control word that matches no code gives an all-zero result.

Top module: `pfx_alu8`

## Requirements
- R1: Control code 0x01 (ADD) gives result = (A + B) mod 256 and carry_out = bit 8 of the 9-bit sum A + B.
- R2: Code 0x02 gives A XOR B, code 0x04 gives A AND B, and code 0x08 gives A OR B.
- R3: Code 0x10 gives NOT A, code 0x20 gives NOT B, and code 0x0C passes A through unchanged.
- R4: Code 0x40 gives NOT (A AND B), code 0x80 gives NOT (A OR B), and code 0x03 gives NOT (A XOR B).
- R5: A control word equal to none of the ten codes gives result 0x00 and carry_out 0.
- R6: carry_out is 0 whenever the control word is not ADD, whatever the operand values.
- R7: Outputs change only at a rising clock edge. Each rising edge captures the function of the inputs that were present at that edge.
- R8: A synchronous active-low reset (rst_n = 0 at a rising edge) sets result to 0x00 and carry_out to 0.
- R9: The carry network handles full-length propagation: 0xFF + 0x01 gives 0x00 with carry 1, and 0x80 + 0x80 gives 0x00 with carry 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_a | input | 8 | Operand A |
| op_b | input | 8 | Operand B |
| ctrl | input | 8 | Function control word |
| result | output | 8 | Registered result |
| carry_out | output | 1 | Registered carry-out from addition |

## Verification
The assertions assume that the ten control codes are pairwise distinct. Under that assumption, at most one candidate gate opens in any cycle, and the AND-OR merge never combines two functions. The assertions also assume that operand and control inputs are stable around the rising edge. The bench changes these inputs only at falling edges, and it draws control words either from the code table or from random values that it screens against that table.

// File: rtl/pfx_alu_pkg.sv
// Package: shared widths and function codes for the prefix-carry ALU.
// Assumes the code values are pairwise distinct, so at most one matches.
package pfx_alu_pkg;

    localparam int CTRL_W = 8;
    localparam int NFUNC  = 10;

    typedef enum logic [3:0] {
        F_ADD   = 4'd0,
        F_XOR   = 4'd1,
        F_AND   = 4'd2,
        F_OR    = 4'd3,
        F_NOTA  = 4'd4,
        F_NOTB  = 4'd5,
        F_NAND  = 4'd6,
        F_NOR   = 4'd7,
        F_XNOR  = 4'd8,
        F_PASSA = 4'd9
    } func_idx_t;

    // Returns the control code that selects a given function slot.
    function automatic logic [CTRL_W-1:0] func_code(input int idx);
        case (idx)
            0:       return 8'h01;
            1:       return 8'h02;
            2:       return 8'h04;
            3:       return 8'h08;
            4:       return 8'h10;
            5:       return 8'h20;
            6:       return 8'h40;
            7:       return 8'h80;
            8:       return 8'h03;
            default: return 8'h0C;
        endcase
    endfunction

endpackage

// File: rtl/pfx_bk_carry.sv
// Module: Brent-Kung parallel-prefix carry network.
// Takes per-bit generate/propagate and returns the carry out of each bit
// with the carry-in fixed at zero. Assumes W is a power of two.
module pfx_bk_carry #(
    parameter int W = 8
) (
    input  logic [W-1:0] gen,
    input  logic [W-1:0] prop,
    output logic [W-1:0] carry
);
    localparam int LVL = $clog2(W);

    logic [W-1:0] g_n;
    logic [W-1:0] p_n;

    // Up-sweep then down-sweep of the (g,p) prefix operator.
    always_comb begin
        g_n = gen;
        p_n = prop;
        for (int l = 0; l < LVL; l++) begin
            for (int i = 0; i < W; i++) begin
                if (((i + 1) % (2 ** (l + 1))) == 0) begin
                    g_n[i] = g_n[i] | (p_n[i] & g_n[i - 2 ** l]);
                    p_n[i] = p_n[i] & p_n[i - 2 ** l];
                end
            end
        end
        for (int l = LVL - 2; l >= 0; l--) begin
            for (int i = 0; i < W; i++) begin
                if ((((i + 1) % (2 ** (l + 1))) == 2 ** l) && (i > 2 ** l)) begin
                    g_n[i] = g_n[i] | (p_n[i] & g_n[i - 2 ** l]);
                    p_n[i] = p_n[i] & p_n[i - 2 ** l];
                end
            end
        end
        carry = g_n;
    end

    // Guard: a carry can only leave a bit that generates or propagates (R1).
    always_comb begin
        // R1
        carry_src_chk: assert ((carry & ~(gen | prop)) == '0)
            else $error("carry without generate or propagate");
        // R1
        no_gen_no_carry_chk: assert ((|gen) || !(|carry))
            else $error("carry present with no generate anywhere");
    end

endmodule

// File: rtl/pfx_and_or_sel.sv
// Module: wide AND-OR selection stage.
// Each candidate word is gated by its own select line and all gated words
// are ORed together. Assumes at most one select line is high.
module pfx_and_or_sel #(
    parameter int W  = 8,
    parameter int NF = 10
) (
    input  logic [NF-1:0][W-1:0] cand,
    input  logic [NF-1:0]        hit,
    output logic [W-1:0]         y
);
    // Merge the gated candidates into one word.
    always_comb begin
        y = '0;
        for (int f = 0; f < NF; f++) begin
            y = y | (cand[f] & {W{hit[f]}});
        end
    end

    // Guard the single-selection assumption (R5).
    always_comb begin
        // R5
        one_hit_chk: assert ($onehot0(hit))
            else $error("more than one function selected");
    end

endmodule

// File: rtl/pfx_alu8.sv
// Module: top of the registered prefix-carry ALU.
// Decodes the control word into one hit line per function, builds all
// candidate results, selects through the AND-OR stage and registers the
// result and carry. Reset is synchronous and active low.
module pfx_alu8
    import pfx_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      op_a,
    input  logic [W-1:0]      op_b,
    input  logic [CTRL_W-1:0] ctrl,
    output logic [W-1:0]      result,
    output logic              carry_out
);
    localparam int CW = W + 1;   // selected word carries the carry bit on top

    logic [W-1:0]           gen_w;
    logic [W-1:0]           prop_w;
    logic [W-1:0]           carry_w;
    logic [W-1:0]           sum_w;
    logic [NFUNC-1:0]       hit;
    logic [NFUNC-1:0][CW-1:0] cand;
    logic [CW-1:0]          sel_w;

    assign gen_w  = op_a & op_b;
    assign prop_w = op_a ^ op_b;

    pfx_bk_carry #(.W(W)) u_carry (
        .gen   (gen_w),
        .prop  (prop_w),
        .carry (carry_w)
    );

    // Sum bits: propagate XOR carry from the bit below (carry-in is zero).
    always_comb begin
        sum_w = prop_w ^ {carry_w[W-2:0], 1'b0};
    end

    // One decoder per function slot.
    for (genvar f = 0; f < NFUNC; f++) begin : g_dec
        assign hit[f] = (ctrl == func_code(f));
    end

    // Candidate results; only the adder drives the top (carry) bit.
    always_comb begin
        cand[F_ADD]   = {carry_w[W-1], sum_w};
        cand[F_XOR]   = {1'b0, op_a ^ op_b};
        cand[F_AND]   = {1'b0, op_a & op_b};
        cand[F_OR]    = {1'b0, op_a | op_b};
        cand[F_NOTA]  = {1'b0, ~op_a};
        cand[F_NOTB]  = {1'b0, ~op_b};
        cand[F_NAND]  = {1'b0, ~(op_a & op_b)};
        cand[F_NOR]   = {1'b0, ~(op_a | op_b)};
        cand[F_XNOR]  = {1'b0, ~(op_a ^ op_b)};
        cand[F_PASSA] = {1'b0, op_a};
    end

    pfx_and_or_sel #(.W(CW), .NF(NFUNC)) u_sel (
        .cand (cand),
        .hit  (hit),
        .y    (sel_w)
    );

    // Output registers with synchronous active-low clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result    <= '0;
            carry_out <= 1'b0;
        end else begin
            result    <= sel_w[W-1:0];
            carry_out <= sel_w[W];
        end
    end

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (result == '0 && !carry_out))
        else $error("reset did not clear outputs");

    // R6
    carry_only_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl != func_code(F_ADD)) |=> !carry_out)
        else $error("carry set outside addition");

    // R5
    unknown_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit == '0) |=> (result == '0 && !carry_out))
        else $error("unknown code gave nonzero output");

    // R7
    hold_inputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(op_a) && $stable(op_b) && $stable(ctrl) && $past(rst_n))
        |=> $stable(result))
        else $error("result moved with steady inputs");

endmodule

// File: tb/tb_pfx_alu8.sv
module tb_pfx_alu8;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] op_a, op_b, ctrl;
    logic [7:0] result;
    logic       carry_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    pfx_alu8 dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_a      (op_a),
        .op_b      (op_b),
        .ctrl      (ctrl),
        .result    (result),
        .carry_out (carry_out)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [7:0] code_of(input int i);
        logic [7:0] t [10] = '{8'h01, 8'h02, 8'h04, 8'h08, 8'h10,
                               8'h20, 8'h40, 8'h80, 8'h03, 8'h0C};
        return t[i];
    endfunction

    function automatic bit is_known(input logic [7:0] c);
        for (int i = 0; i < 10; i++) if (code_of(i) == c) return 1;
        return 0;
    endfunction

    // Reference model written from the requirements: {carry, result}.
    function automatic logic [8:0] ref_out(input logic [7:0] c, a, b);
        case (c)
            8'h01: return {1'b0, a} + {1'b0, b};
            8'h02: return {1'b0, a ^ b};
            8'h04: return {1'b0, a & b};
            8'h08: return {1'b0, a | b};
            8'h10: return {1'b0, ~a};
            8'h20: return {1'b0, ~b};
            8'h0C: return {1'b0, a};
            8'h40: return {1'b0, ~(a & b)};
            8'h80: return {1'b0, ~(a | b)};
            8'h03: return {1'b0, ~(a ^ b)};
            default: return 9'h000;
        endcase
    endfunction

    function automatic string req_of(input logic [7:0] c);
        case (c)
            8'h01: return "R1";
            8'h02, 8'h04, 8'h08: return "R2";
            8'h10, 8'h20, 8'h0C: return "R3";
            8'h40, 8'h80, 8'h03: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic check(input string req, input logic [8:0] exp);
        n_chk++;
        if ({carry_out, result} !== exp) begin
            n_fail++;
            $display("FAIL %s: got carry=%0b res=%02h, expected carry=%0b res=%02h",
                     req, carry_out, result, exp[8], exp[7:0]);
        end
    endtask

    // Drive at a falling edge, check at the next falling edge (R7).
    task automatic apply(input logic [7:0] c, a, b, input string req);
        @(negedge clk);
        ctrl = c; op_a = a; op_b = b;
        @(negedge clk);
        check(req, ref_out(c, a, b));
        if (c != 8'h01) begin
            n_chk++;
            if (carry_out !== 1'b0) begin
                n_fail++;
                $display("FAIL R6: got carry=%0b, expected carry=0", carry_out);
            end
        end
    endtask

    initial begin
        rst_n = 1'b0; op_a = 8'hFF; op_b = 8'hFF; ctrl = 8'h08;
        @(negedge clk); @(negedge clk);
        check("R8", 9'h000);            // reset state with live inputs
        rst_n = 1'b1;

        // R9: carry corner cases
        apply(8'h01, 8'hFF, 8'h01, "R9");
        apply(8'h01, 8'h80, 8'h80, "R9");
        apply(8'h01, 8'hFF, 8'hFF, "R1");
        apply(8'h01, 8'h00, 8'h00, "R1");
        apply(8'h01, 8'h55, 8'hAA, "R1");
        // every function on fixed patterns (R2 R3 R4)
        for (int i = 0; i < 10; i++) begin
            apply(code_of(i), 8'hF0, 8'h3C, req_of(code_of(i)));
            apply(code_of(i), 8'hFF, 8'hFF, req_of(code_of(i)));
        end
        // R5: unknown codes with operands that would carry
        apply(8'h00, 8'hFF, 8'hFF, "R5");
        apply(8'hFF, 8'hFF, 8'h01, "R5");
        apply(8'h05, 8'hAB, 8'hCD, "R5");

        // R7: hold inputs across an edge, result must stay; then change inputs
        // at a falling edge and confirm the old value until the next rising edge
        @(negedge clk); ctrl = 8'h01; op_a = 8'h12; op_b = 8'h34;
        @(negedge clk); check("R7", 9'h046);
        op_a = 8'h00;
        #1 check("R7", 9'h046);
        @(negedge clk); check("R7", 9'h034);

        // Constrained random mix of known and unknown codes
        void'($urandom(32'd4242));
        for (int k = 0; k < 3000; k++) begin
            logic [7:0] c;
            if (($urandom % 8) == 0) begin
                c = 8'($urandom);
                while (is_known(c)) c = 8'($urandom);
            end else begin
                c = code_of($urandom % 10);
            end
            apply(c, 8'($urandom), 8'($urandom), req_of(c));
        end

        // R8: reset while running
        @(negedge clk); ctrl = 8'h01; op_a = 8'hFF; op_b = 8'h01; rst_n = 1'b0;
        @(negedge clk); check("R8", 9'h000);
        rst_n = 1'b1;
        @(negedge clk); check("R8", 9'h100);

        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog: got timeout, expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule